// File: doc/BRIEF.md
# Programmable Bus Wait-State Generator

This block stretches the external bus accesses of a processor core. It holds one control word with a separate 3-bit wait count for each of three external spaces: program, data and I/O. When the core begins an external access, the block holds its ready line low for the programmed number of cycles for the selected space. Once that count has run out, it waits for the external READY input. A slow device can therefore add cycles on top of the programmed count but can never shorten it.

The control word is written through the I/O bus at one fixed address. Reset fills every field with ones, so each space starts with the slowest setting of seven wait cycles. A new setting only affects accesses that start after the write. An access already in flight keeps the count it loaded.

Top module: `bus_wait_gen`

## Requirements
- R1: After reset `cfg_value` reads 16'h01FF and every space inserts 7 wait cycles.
- R2: Field layout: bits [2:0] set the program-space count (`acc_space` = 0), bits [5:3] the data-space count (`acc_space` = 1), and bits [8:6] the I/O-space count (`acc_space` = 2). Code 3 uses the I/O-space field.
- R3: A write with `io_wr_en` high and `io_addr` = 16'hFFFF loads `io_wdata[8:0]` into the control word at the next clock edge. Writes to any other address leave it unchanged.
- R4: Bits [15:9] of `cfg_value` always read zero, whatever value is written.
- R5: With READY high, an access to a space whose count is N (N > 0) holds `core_ready` low for exactly N cycles. The strobe cycle is the first of these, and `core_ready` is high in cycle N.
- R6: With a count of 0 and READY high, `core_ready` stays high in the strobe cycle and the access completes with no stall.
- R7: READY is sampled only after the count is exhausted. If READY is low there, `core_ready` stays low until the first cycle in which READY is high, giving max(N, L) stall cycles when READY is low for the first L cycles of the access.
- R8: READY being low while the programmed count is still running adds no cycles beyond the count.
- R9: An `acc_start` pulse during an access in progress is ignored: that access's length is unchanged and no second access follows.
- R10: A control-word write during an access does not change that access. The next access uses the new count.
- R11: With no access in progress and no strobe, `core_ready` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| io_wr_en | input | 1 | I/O bus write strobe |
| io_addr | input | 16 | I/O bus address |
| io_wdata | input | 16 | I/O bus write data |
| cfg_value | output | 16 | Control word read value |
| acc_start | input | 1 | Start of an external access |
| acc_space | input | 2 | Space of the access: 0 program, 1 data, 2 and 3 I/O |
| ext_ready | input | 1 | External READY from the addressed device |
| core_ready | output | 1 | Ready to the core; low during every wait cycle |

## Verification
Accesses run with READY held high across counts of 0, 1, 2, 4 and 7. These tell the programmed count apart from any READY effect and expose off-by-one errors at both ends of the range. READY is then held low for a while, once ending before the count runs out and once ending after it. The first case shows that READY is ignored while counting; the second shows that it extends the access. Writes to a neighbouring address, writes with upper bits set, and a write and a second strobe landing inside a running access separate the address decode and the field masking from the rule that a loaded count is never disturbed.

// File: rtl/bwg_pkg.sv
package bwg_pkg;
   typedef enum logic [1:0] {
      SPC_PROG = 2'd0,
      SPC_DATA = 2'd1,
      SPC_IO   = 2'd2
   } space_e;
endpackage

// File: rtl/bwg_cfg_reg.sv
module bwg_cfg_reg #(
   parameter int ADDR_W     = 16,
   parameter int DATA_W     = 16,
   parameter int FIELD_BITS = 9,
   parameter logic [ADDR_W-1:0] CFG_ADDR = '1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [ADDR_W-1:0]     addr,
   input  logic [DATA_W-1:0]     wdata,
   output logic [FIELD_BITS-1:0] cfg_q,
   output logic [DATA_W-1:0]     rd_value
);
   logic hit;
   assign hit = wr_en && (addr == CFG_ADDR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cfg_q <= '1;
      else if (hit) cfg_q <= wdata[FIELD_BITS-1:0];
   end

   generate
      if (DATA_W > FIELD_BITS) begin : g_pad
         assign rd_value = {{(DATA_W-FIELD_BITS){1'b0}}, cfg_q};
      end else begin : g_nopad
         assign rd_value = cfg_q;
      end
   endgenerate
endmodule

// File: rtl/bwg_stall_fsm.sv
module bwg_stall_fsm #(
   parameter int CNT_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [CNT_W-1:0] load_cnt,
   input  logic             ext_ready,
   output logic             core_ready,
   output logic             busy,
   output logic [CNT_W-1:0] rem
);
   logic             nxt_busy;
   logic [CNT_W-1:0] nxt_rem;

   always_comb begin
      core_ready = 1'b1;
      nxt_busy   = busy;
      nxt_rem    = rem;
      if (!busy) begin
         if (start && !(load_cnt == '0 && ext_ready)) begin
            core_ready = 1'b0;
            nxt_busy   = 1'b1;
            nxt_rem    = (load_cnt == '0) ? '0 : load_cnt - 1'b1;
         end
      end else if (rem != '0) begin
         core_ready = 1'b0;
         nxt_rem    = rem - 1'b1;
      end else if (ext_ready) begin
         nxt_busy = 1'b0;
      end else begin
         core_ready = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         rem  <= '0;
      end else begin
         busy <= nxt_busy;
         rem  <= nxt_rem;
      end
   end
endmodule

// File: rtl/bus_wait_gen.sv
module bus_wait_gen #(
   parameter int CNT_W      = 3,
   parameter int NUM_SPACES = 3,
   parameter int ADDR_W     = 16,
   parameter int DATA_W     = 16,
   parameter logic [ADDR_W-1:0] CFG_ADDR = 16'hFFFF,
   localparam int SEL_W      = (NUM_SPACES > 1) ? $clog2(NUM_SPACES) : 1,
   localparam int FIELD_BITS = CNT_W * NUM_SPACES
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              io_wr_en,
   input  logic [ADDR_W-1:0] io_addr,
   input  logic [DATA_W-1:0] io_wdata,
   output logic [DATA_W-1:0] cfg_value,
   input  logic              acc_start,
   input  logic [SEL_W-1:0]  acc_space,
   input  logic              ext_ready,
   output logic              core_ready
);
   generate
      if (CNT_W < 1 || NUM_SPACES < 1) begin : g_bad_shape
         $error("bus_wait_gen: CNT_W and NUM_SPACES must be positive");
      end
      if (FIELD_BITS > DATA_W) begin : g_bad_width
         $error("bus_wait_gen: fields do not fit in DATA_W");
      end
   endgenerate

   logic [FIELD_BITS-1:0] cfg_q;
   logic [CNT_W-1:0]      cnt_arr [NUM_SPACES];
   logic [CNT_W-1:0]      sel_cnt;
   logic                  busy;
   logic [CNT_W-1:0]      rem_cnt;

   bwg_cfg_reg #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W),
      .FIELD_BITS(FIELD_BITS), .CFG_ADDR(CFG_ADDR)
   ) u_cfg (
      .clk(clk), .rst_n(rst_n), .wr_en(io_wr_en), .addr(io_addr),
      .wdata(io_wdata), .cfg_q(cfg_q), .rd_value(cfg_value)
   );

   genvar gi;
   generate
      for (gi = 0; gi < NUM_SPACES; gi++) begin : g_field
         assign cnt_arr[gi] = cfg_q[gi*CNT_W +: CNT_W];
      end
   endgenerate

   always_comb begin
      sel_cnt = cnt_arr[NUM_SPACES-1];
      for (int i = 0; i < NUM_SPACES; i++) begin
         if (int'(acc_space) == i) sel_cnt = cnt_arr[i];
      end
   end

   bwg_stall_fsm #(.CNT_W(CNT_W)) u_fsm (
      .clk(clk), .rst_n(rst_n), .start(acc_start), .load_cnt(sel_cnt),
      .ext_ready(ext_ready), .core_ready(core_ready),
      .busy(busy), .rem(rem_cnt)
   );
endmodule

// File: rtl/bwg_checker.sv
module bwg_checker #(
   parameter int CNT_W  = 3,
   parameter int DATA_W = 16,
   parameter int FIELD_BITS = 9
) (
   input logic              clk,
   input logic              rst_n,
   input logic              acc_start,
   input logic              ext_ready,
   input logic              core_ready,
   input logic              busy,
   input logic [CNT_W-1:0]  rem_cnt,
   input logic [CNT_W-1:0]  sel_cnt,
   input logic [DATA_W-1:0] cfg_value
);
   AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_value[DATA_W-1:FIELD_BITS] == '0);                               // R4
   AST_LOW_WHILE_COUNTING: assert property (@(posedge clk) disable iff (!rst_n)
      busy && rem_cnt != '0 |-> !core_ready);                              // R5
   AST_ZERO_WAIT_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      !busy && acc_start && sel_cnt == '0 && ext_ready |-> core_ready ##1 !busy); // R6
   AST_DONE_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
      busy && core_ready |-> ext_ready && rem_cnt == '0);                  // R7
   AST_COUNT_UNDISTURBED: assert property (@(posedge clk) disable iff (!rst_n)
      busy && rem_cnt != '0 |=> busy && rem_cnt == $past(rem_cnt) - 1'b1); // R9
   AST_IDLE_READY: assert property (@(posedge clk) disable iff (!rst_n)
      !busy && !acc_start |-> core_ready);                                 // R11
endmodule

bind bus_wait_gen bwg_checker #(
   .CNT_W(CNT_W), .DATA_W(DATA_W), .FIELD_BITS(FIELD_BITS)
) u_chk (
   .clk(clk), .rst_n(rst_n), .acc_start(acc_start), .ext_ready(ext_ready),
   .core_ready(core_ready), .busy(busy), .rem_cnt(rem_cnt),
   .sel_cnt(sel_cnt), .cfg_value(cfg_value)
);

// File: tb/bus_wait_gen_bench.sv
`timescale 1ns/1ps
module bus_wait_gen_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        io_wr_en = 1'b0;
   logic [15:0] io_addr = '0;
   logic [15:0] io_wdata = '0;
   logic [15:0] cfg_value;
   logic        acc_start = 1'b0;
   logic [1:0]  acc_space = '0;
   logic        ext_ready = 1'b1;
   logic        core_ready;
   int          n_chk = 0;
   int          n_bad = 0;

   always #2.5 clk = ~clk;

   bus_wait_gen u_bus_wait_gen (
      .clk(clk), .rst_n(rst_n), .io_wr_en(io_wr_en), .io_addr(io_addr),
      .io_wdata(io_wdata), .cfg_value(cfg_value), .acc_start(acc_start),
      .acc_space(acc_space), .ext_ready(ext_ready), .core_ready(core_ready)
   );

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: got %0d (0x%0h), expected %0d (0x%0h)", req, act, act, exp, exp);
      end
   endtask

   task automatic cfg_write(input logic [15:0] a, input logic [15:0] d);
      @(negedge clk);
      io_wr_en = 1'b1; io_addr = a; io_wdata = d;
      @(negedge clk);
      io_wr_en = 1'b0;
   endtask

   // Runs one access; returns number of cycles core_ready was low.
   task automatic run_access(input logic [1:0] spc, input int ready_low,
                             input int strobe_again_at, input int write_at,
                             input logic [15:0] wdata, output int stalls);
      stalls = 0;
      @(negedge clk);
      acc_start = 1'b1; acc_space = spc; ext_ready = (ready_low == 0);
      #1;
      while (!core_ready && stalls < 40) begin
         @(negedge clk);
         stalls++;
         acc_start = (stalls == strobe_again_at);
         io_wr_en  = (stalls == write_at);
         io_addr   = 16'hFFFF; io_wdata = wdata;
         ext_ready = (stalls >= ready_low);
         #1;
      end
      @(negedge clk);
      acc_start = 1'b0; io_wr_en = 1'b0; ext_ready = 1'b1;
   endtask

   task automatic t_reset;
      int s;
      check("R1 reset word", int'(cfg_value), 16'h01FF);
      check("R11 idle ready", int'(core_ready), 1);
      run_access(2'd0, 0, -1, -1, 16'h0, s); check("R1 prog 7 waits", s, 7);
      run_access(2'd1, 0, -1, -1, 16'h0, s); check("R1 data 7 waits", s, 7);
   endtask

   task automatic t_layout;
      int s;
      cfg_write(16'hFFFF, 16'hF1D1);
      check("R4 upper bits zero", int'(cfg_value), 16'h01D1);
      run_access(2'd0, 0, -1, -1, 16'h0, s); check("R2 prog field", s, 1);
      run_access(2'd1, 0, -1, -1, 16'h0, s); check("R2 data field", s, 2);
      run_access(2'd2, 0, -1, -1, 16'h0, s); check("R2 io field", s, 7);
      run_access(2'd3, 0, -1, -1, 16'h0, s); check("R2 code 3 io", s, 7);
   endtask

   task automatic t_decode;
      cfg_write(16'hFFFE, 16'h0000);
      check("R3 other address ignored", int'(cfg_value), 16'h01D1);
      cfg_write(16'hFFFF, 16'h0000);
      check("R3 write loads", int'(cfg_value), 0);
   endtask

   task automatic t_zero_wait;
      int s;
      #1; check("R11 idle ready", int'(core_ready), 1);
      run_access(2'd0, 0, -1, -1, 16'h0, s); check("R6 zero wait", s, 0);
      run_access(2'd1, 3, -1, -1, 16'h0, s); check("R7 ready extends", s, 3);
   endtask

   task automatic t_ready_overlap;
      int s;
      cfg_write(16'hFFFF, 16'h0084);  // prog 4, data 0, io 2
      run_access(2'd0, 2, -1, -1, 16'h0, s); check("R8 early ready low", s, 4);
      run_access(2'd2, 5, -1, -1, 16'h0, s); check("R7 late ready", s, 5);
      run_access(2'd0, 0, -1, -1, 16'h0, s); check("R5 count 4", s, 4);
   endtask

   task automatic t_busy_strobe;
      int s;
      run_access(2'd0, 0, 2, -1, 16'h0, s); check("R9 strobe ignored", s, 4);
      #1; check("R9 no extra access", int'(core_ready), 1);
      @(negedge clk); #1; check("R9 still idle", int'(core_ready), 1);
   endtask

   task automatic t_midwrite;
      int s;
      run_access(2'd0, 0, -1, 1, 16'h0001, s); check("R10 in-flight kept", s, 4);
      check("R10 word updated", int'(cfg_value), 16'h0001);
      run_access(2'd0, 0, -1, -1, 16'h0, s); check("R10 next uses new", s, 1);
   endtask

   initial begin
      #200000;
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      t_reset();
      t_layout();
      t_decode();
      t_zero_wait();
      t_ready_overlap();
      t_busy_strobe();
      t_midwrite();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule